// File: doc/BRIEF.md
# Timestamp Event Queue

This block collects time-stamped events from fifteen sources into one first-in, first-out queue. The sources are a software push strobe, a counter rollover strobe, a half-rollover strobe, a set of hardware capture inputs, a receive and a transmit event carrying packet identification fields, a compare-match strobe and a host transmit strobe. When a source fires, the block tags the event with the current value of the 64-bit time input. The time counter and the logic that produces the events sit outside the block.

Software reads the oldest entry as four 32-bit words through a small register port. It retires that entry by writing a pop command. A raw status bit shows that the queue holds at least one entry. The interrupt line is that bit gated by an enable register. Each hardware capture input has its own enable bit in the control register, and a capture happens only on a rising edge of an enabled input.

Each source has a one-entry holding stage. When several sources fire together, the holding stages drain into the queue one per cycle in a fixed priority order. When there is no room, events are discarded and a sticky overflow bit is set.

Top module: `tsqTop`

## Requirements
- R1: The oldest entry reads as follows. Address 5 gives timestamp bits 31:0 and address 8 gives timestamp bits 63:32. Address 6 gives the sequence ID in bits 15:0, the message type in 19:16, the event type in 23:20 and the port in 28:24. Address 7 gives the domain in bits 7:0. All four words read zero while the queue is empty.
- R2: The event type codes are: software push 0, rollover 1, half rollover 2, hardware capture 3, receive 4, transmit 5, compare 6, host transmit 7. Only receive and transmit events carry port, message type, sequence ID and domain from their inputs; the other sources leave those fields zero.
- R3: Hardware input i is captured on a rising edge only while bit 8+i of the control register (address 0, readable) is 1. A level held high gives one event. The port field of a capture is i+1.
- R4: Bit 0 of the raw status register (address 1) is 1 exactly while the queue is not empty.
- R5: Writing 1 to bit 0 at address 4 removes the oldest entry, and entries leave in the order they entered.
- R6: A pop while the queue is empty changes nothing, and later events are stored and read normally.
- R7: With the queue holding DEPTH entries, a further event is discarded and the older entries are kept. The same holds for an event whose holding stage is still occupied. Bit 1 of the raw status register then becomes 1 and stays 1 until 1 is written to that bit.
- R8: Bit 0 of the masked status register (address 2) and the irq output both equal raw pending ANDed with bit 0 of the interrupt enable register (address 3).
- R9: Sources that fire in the same cycle enter the queue one per cycle in this order: push, rollover, half rollover, hardware inputs in ascending index, receive, transmit, compare, host transmit.
- R10: After reset the queue is empty, the overflow bit is 0, all capture enables and the interrupt enable are 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| curTime | input | 64 | Current time value used to tag events |
| pushReq | input | 1 | Software push event strobe |
| rollReq | input | 1 | Rollover event strobe |
| halfReq | input | 1 | Half-rollover event strobe |
| hwIn | input | NUM_HW | Hardware capture inputs (level) |
| rxReq | input | 1 | Receive event strobe |
| rxPort | input | 5 | Receive port number |
| rxMsgType | input | 4 | Receive message type |
| rxSeqId | input | 16 | Receive sequence ID |
| rxDomain | input | 8 | Receive domain |
| txReq | input | 1 | Transmit event strobe |
| txPort | input | 5 | Transmit port number |
| txMsgType | input | 4 | Transmit message type |
| txSeqId | input | 16 | Transmit sequence ID |
| txDomain | input | 8 | Transmit domain |
| cmpReq | input | 1 | Compare-match event strobe |
| hostReq | input | 1 | Host transmit event strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 4 and NUM_HW kept at 8. The shallow queue brings the full and overflow cases within a few events. It also lets a burst of four simultaneous sources fill the queue exactly without loss. Keeping all eight capture inputs exercises both ends of the enable field and the largest hardware port number.

// File: rtl/tsqPkg.sv
package tsqPkg;

  localparam int SRC_IDX_W = 5;

  typedef enum logic [3:0] {
    EV_PUSH = 4'd0,
    EV_ROLL = 4'd1,
    EV_HALF = 4'd2,
    EV_HWIN = 4'd3,
    EV_RECV = 4'd4,
    EV_XMIT = 4'd5,
    EV_CMP  = 4'd6,
    EV_HOST = 4'd7
  } evKind_e;

  typedef struct packed {
    logic [63:0] stamp;
    logic [3:0]  kind;
    logic [4:0]  port;
    logic [3:0]  msgType;
    logic [15:0] seqId;
    logic [7:0]  domain;
  } evEntry_t;

  typedef struct packed {
    logic                 wrEn;
    logic                 popEn;
    logic [SRC_IDX_W-1:0] wrSel;
  } tsqStrobe_t;

  localparam logic [3:0] ADDR_CTRL  = 4'd0;
  localparam logic [3:0] ADDR_RAW   = 4'd1;
  localparam logic [3:0] ADDR_MASK  = 4'd2;
  localparam logic [3:0] ADDR_INTEN = 4'd3;
  localparam logic [3:0] ADDR_POP   = 4'd4;
  localparam logic [3:0] ADDR_WORD0 = 4'd5;
  localparam logic [3:0] ADDR_WORD1 = 4'd6;
  localparam logic [3:0] ADDR_WORD2 = 4'd7;
  localparam logic [3:0] ADDR_WORD3 = 4'd8;

endpackage

// File: rtl/tsqCtrl.sv
module tsqCtrl
  import tsqPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_HW = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pushReq,
  input  logic                   rollReq,
  input  logic                   halfReq,
  input  logic [NUM_HW-1:0]      hwIn,
  input  logic                   rxReq,
  input  logic                   txReq,
  input  logic                   cmpReq,
  input  logic                   hostReq,
  input  logic                   regWrEn,
  input  logic [3:0]             regAddr,
  input  logic [31:0]            regWrData,
  output logic [NUM_HW+6:0]      holdLoad,
  output tsqStrobe_t             st,
  output logic [NUM_HW-1:0]      hwEn,
  output logic                   intEn,
  output logic                   pending,
  output logic                   ovf,
  output logic                   irq
);

  localparam int NUM_SRC  = NUM_HW + 7;
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int SRC_RX   = 3 + NUM_HW;
  localparam int SRC_TX   = 4 + NUM_HW;
  localparam int SRC_CMP  = 5 + NUM_HW;
  localparam int SRC_HOST = 6 + NUM_HW;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [NUM_HW-1:0]  hwPrev;
  logic [NUM_HW-1:0]  hwEdge;
  logic [NUM_SRC-1:0] srcReq;
  logic [NUM_SRC-1:0] holdValid;
  logic [NUM_SRC-1:0] grant;
  logic [SRC_IDX_W-1:0] selIdx;
  logic [CNT_W-1:0]   count;
  logic               anyHold;
  logic               popWrite;
  logic               ovfClear;
  logic               room;
  logic               dropNow;
  logic               lostHold;

  assign hwEdge = hwIn & ~hwPrev & hwEn;

  always_comb begin
    srcReq           = '0;
    srcReq[0]        = pushReq;
    srcReq[1]        = rollReq;
    srcReq[2]        = halfReq;
    srcReq[3 +: NUM_HW] = hwEdge;
    srcReq[SRC_RX]   = rxReq;
    srcReq[SRC_TX]   = txReq;
    srcReq[SRC_CMP]  = cmpReq;
    srcReq[SRC_HOST] = hostReq;
  end

  // fixed priority: the lowest source index wins
  always_comb begin
    grant  = '0;
    selIdx = '0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (holdValid[s]) begin
        grant  = '0;
        grant[s] = 1'b1;
        selIdx = SRC_IDX_W'(s);
      end
    end
  end

  assign anyHold  = |holdValid;
  assign popWrite = regWrEn && (regAddr == ADDR_POP) && regWrData[0];
  assign ovfClear = regWrEn && (regAddr == ADDR_RAW) && regWrData[1];
  assign pending  = (count != '0);

  always_comb begin
    st       = '0;
    st.popEn = popWrite && pending;
    room     = (count != CNT_FULL) || st.popEn;
    st.wrEn  = anyHold && room;
    st.wrSel = selIdx;
    dropNow  = anyHold && !room;
    holdLoad = srcReq & (~holdValid | grant);
    lostHold = |(srcReq & holdValid & ~grant);
  end

  assign irq = pending && intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwPrev    <= '0;
      holdValid <= '0;
      count     <= '0;
      hwEn      <= '0;
      intEn     <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      hwPrev    <= hwIn;
      holdValid <= (holdValid & ~grant) | holdLoad;
      count     <= count + CNT_W'(st.wrEn) - CNT_W'(st.popEn);
      if (regWrEn && regAddr == ADDR_CTRL)  hwEn  <= regWrData[8 +: NUM_HW];
      if (regWrEn && regAddr == ADDR_INTEN) intEn <= regWrData[0];
      if (dropNow || lostHold)  ovf <= 1'b1;
      else if (ovfClear)        ovf <= 1'b0;
    end
  end

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovf && !(regWrEn && regAddr == ADDR_RAW && regWrData[1]) |=> ovf); // R7

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    popWrite && count == '0 && !anyHold |=> count == '0); // R6

  AST_LOW_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    holdValid[SRC_HOST] && (|holdValid[SRC_HOST-1:0]) |=> holdValid[SRC_HOST]); // R9

  AST_IRQ_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> count != '0); // R8

  for (genvar i = 0; i < NUM_HW; i++) begin : g_hwChk
    AST_HW_GATED: assert property (@(posedge clk) disable iff (!rstN)
      $rose(holdValid[3+i]) |-> $past(hwEn[i])); // R3
  end

endmodule

// File: rtl/tsqData.sv
module tsqData
  import tsqPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_HW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       curTime,
  input  logic [4:0]        rxPort,
  input  logic [3:0]        rxMsgType,
  input  logic [15:0]       rxSeqId,
  input  logic [7:0]        rxDomain,
  input  logic [4:0]        txPort,
  input  logic [3:0]        txMsgType,
  input  logic [15:0]       txSeqId,
  input  logic [7:0]        txDomain,
  input  logic [NUM_HW+6:0] holdLoad,
  input  tsqStrobe_t        st,
  output evEntry_t          head
);

  localparam int NUM_SRC = NUM_HW + 7;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  evEntry_t srcEntry [NUM_SRC];
  evEntry_t holdReg  [NUM_SRC];
  evEntry_t store    [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      srcEntry[s]       = '0;
      srcEntry[s].stamp = curTime;
      if (s < 3) begin
        srcEntry[s].kind = 4'(s);
      end else if (s < 3 + NUM_HW) begin
        srcEntry[s].kind = EV_HWIN;
        srcEntry[s].port = 5'(s - 2);
      end else if (s == 3 + NUM_HW) begin
        srcEntry[s].kind    = EV_RECV;
        srcEntry[s].port    = rxPort;
        srcEntry[s].msgType = rxMsgType;
        srcEntry[s].seqId   = rxSeqId;
        srcEntry[s].domain  = rxDomain;
      end else if (s == 4 + NUM_HW) begin
        srcEntry[s].kind    = EV_XMIT;
        srcEntry[s].port    = txPort;
        srcEntry[s].msgType = txMsgType;
        srcEntry[s].seqId   = txSeqId;
        srcEntry[s].domain  = txDomain;
      end else if (s == 5 + NUM_HW) begin
        srcEntry[s].kind = EV_CMP;
      end else begin
        srcEntry[s].kind = EV_HOST;
      end
    end

    always_ff @(posedge clk) begin
      if (holdLoad[s]) holdReg[s] <= srcEntry[s];
    end
  end

  always_ff @(posedge clk) begin
    if (st.wrEn) store[wrPtr] <= holdReg[st.wrSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (st.wrEn)  wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (st.popEn) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  assign head = store[rdPtr];

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= PTR_LAST && wrPtr <= PTR_LAST); // R5

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |-> int'(st.wrSel) < NUM_SRC); // R9

endmodule

// File: rtl/tsqTop.sv
module tsqTop
  import tsqPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_HW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       curTime,
  input  logic              pushReq,
  input  logic              rollReq,
  input  logic              halfReq,
  input  logic [NUM_HW-1:0] hwIn,
  input  logic              rxReq,
  input  logic [4:0]        rxPort,
  input  logic [3:0]        rxMsgType,
  input  logic [15:0]       rxSeqId,
  input  logic [7:0]        rxDomain,
  input  logic              txReq,
  input  logic [4:0]        txPort,
  input  logic [3:0]        txMsgType,
  input  logic [15:0]       txSeqId,
  input  logic [7:0]        txDomain,
  input  logic              cmpReq,
  input  logic              hostReq,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irq
);

  logic [NUM_HW+6:0] holdLoad;
  tsqStrobe_t        st;
  logic [NUM_HW-1:0] hwEn;
  logic              intEn;
  logic              pending;
  logic              ovf;
  evEntry_t          head;
  evEntry_t          shown;
  logic [31:0]       ctrlWord;

  tsqCtrl #(.DEPTH(DEPTH), .NUM_HW(NUM_HW)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .pushReq(pushReq), .rollReq(rollReq), .halfReq(halfReq), .hwIn(hwIn),
    .rxReq(rxReq), .txReq(txReq), .cmpReq(cmpReq), .hostReq(hostReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .holdLoad(holdLoad), .st(st), .hwEn(hwEn), .intEn(intEn),
    .pending(pending), .ovf(ovf), .irq(irq)
  );

  tsqData #(.DEPTH(DEPTH), .NUM_HW(NUM_HW)) i_data (
    .clk(clk), .rstN(rstN), .curTime(curTime),
    .rxPort(rxPort), .rxMsgType(rxMsgType), .rxSeqId(rxSeqId), .rxDomain(rxDomain),
    .txPort(txPort), .txMsgType(txMsgType), .txSeqId(txSeqId), .txDomain(txDomain),
    .holdLoad(holdLoad), .st(st), .head(head)
  );

  assign shown = pending ? head : '0;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[8 +: NUM_HW] = hwEn;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:  regRdData = ctrlWord;
      ADDR_RAW:   regRdData = {30'b0, ovf, pending};
      ADDR_MASK:  regRdData = {31'b0, pending && intEn};
      ADDR_INTEN: regRdData = {31'b0, intEn};
      ADDR_WORD0: regRdData = shown.stamp[31:0];
      ADDR_WORD1: regRdData = {3'b0, shown.port, shown.kind, shown.msgType, shown.seqId};
      ADDR_WORD2: regRdData = {24'b0, shown.domain};
      ADDR_WORD3: regRdData = shown.stamp[63:32];
      default:    regRdData = '0;
    endcase
  end

  AST_WORDS_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !pending && regAddr == ADDR_WORD1 |-> regRdData == '0); // R1

endmodule

// File: tb/test_tsqTop.sv
`timescale 1ns/1ps
module test_tsqTop;

  localparam int DEPTH  = 4;
  localparam int NUM_HW = 8;

  typedef struct packed {
    logic [4:0]  src;
    logic [4:0]  port;
    logic [3:0]  msg;
    logic [15:0] seq;
    logic [7:0]  dom;
    logic [63:0] ts;
    logic [31:0] expW1;
    logic [31:0] expW2;
  } vec_t;

  // R1 R2 R3: one event per row, read back and popped
  localparam vec_t VEC [9] = '{
    '{5'd0,  5'd0,  4'h0, 16'h0000, 8'h00, 64'h0000_0001_0000_0010, 32'h0000_0000, 32'h0},
    '{5'd1,  5'd0,  4'h0, 16'h0000, 8'h00, 64'h0000_0002_0000_0020, 32'h0010_0000, 32'h0},
    '{5'd2,  5'd0,  4'h0, 16'h0000, 8'h00, 64'h0000_0003_0000_0030, 32'h0020_0000, 32'h0},
    '{5'd3,  5'd0,  4'h0, 16'h0000, 8'h00, 64'h0000_0004_0000_0040, 32'h0130_0000, 32'h0},
    '{5'd10, 5'd0,  4'h0, 16'h0000, 8'h00, 64'h8000_0005_FFFF_0050, 32'h0830_0000, 32'h0},
    '{5'd11, 5'd5,  4'hA, 16'h1234, 8'h5C, 64'h0000_0006_0000_0060, 32'h054A_1234, 32'h5C},
    '{5'd12, 5'd31, 4'h3, 16'hFFFF, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h1F53_FFFF, 32'hFF},
    '{5'd13, 5'd0,  4'h0, 16'h0000, 8'h00, 64'h0000_0008_0000_0080, 32'h0060_0000, 32'h0},
    '{5'd14, 5'd0,  4'h0, 16'h0000, 8'h00, 64'h0000_0009_0000_0090, 32'h0070_0000, 32'h0}
  };

  logic clk = 0;
  logic rstN = 0;
  logic [63:0] curTime = '0;
  logic pushReq = 0, rollReq = 0, halfReq = 0, rxReq = 0, txReq = 0, cmpReq = 0, hostReq = 0;
  logic [NUM_HW-1:0] hwIn = '0;
  logic [4:0] rxPort = '0, txPort = '0;
  logic [3:0] rxMsgType = '0, txMsgType = '0;
  logic [15:0] rxSeqId = '0, txSeqId = '0;
  logic [7:0] rxDomain = '0, txDomain = '0;
  logic regWrEn = 0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tsqTop #(.DEPTH(DEPTH), .NUM_HW(NUM_HW)) i_tsqTop (
    .clk(clk), .rstN(rstN), .curTime(curTime),
    .pushReq(pushReq), .rollReq(rollReq), .halfReq(halfReq), .hwIn(hwIn),
    .rxReq(rxReq), .rxPort(rxPort), .rxMsgType(rxMsgType), .rxSeqId(rxSeqId), .rxDomain(rxDomain),
    .txReq(txReq), .txPort(txPort), .txMsgType(txMsgType), .txSeqId(txSeqId), .txDomain(txDomain),
    .cmpReq(cmpReq), .hostReq(hostReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    regWrData = v;
    regWrEn = 1;
    @(posedge clk);
    #1;
    regWrEn = 0;
  endtask

  task automatic setSrc(input logic [4:0] s, input logic v, input vec_t e);
    if (s == 0) pushReq = v;
    else if (s == 1) rollReq = v;
    else if (s == 2) halfReq = v;
    else if (s < 11) hwIn[s-3] = v;
    else if (s == 11) begin
      rxReq = v; rxPort = e.port; rxMsgType = e.msg; rxSeqId = e.seq; rxDomain = e.dom;
    end else if (s == 12) begin
      txReq = v; txPort = e.port; txMsgType = e.msg; txSeqId = e.seq; txDomain = e.dom;
    end else if (s == 13) cmpReq = v;
    else hostReq = v;
  endtask

  task automatic fire(input vec_t e);
    @(negedge clk);
    curTime = e.ts;
    setSrc(e.src, 1'b1, e);
    @(negedge clk);
    setSrc(e.src, 1'b0, e);
  endtask

  function automatic vec_t pushAt(input logic [63:0] t);
    vec_t e;
    e = '0;
    e.ts = t;
    return e;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    vec_t e;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R10 reset state
    rd(4'd1, d); chk("R10 raw status", d, 32'h0);
    rd(4'd0, d); chk("R10 control", d, 32'h0);
    rd(4'd3, d); chk("R10 int enable", d, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);
    rd(4'd6, d); chk("R1 word1 empty", d, 32'h0);

    wr(4'd0, 32'h0000_FF00);
    rd(4'd0, d); chk("R3 control readback", d, 32'h0000_FF00);

    // table walk: R1 R2 R4 R5
    for (int k = 0; k < 9; k++) begin
      fire(VEC[k]);
      rd(4'd1, d); chk("R4 pending set", d, 32'h1);
      rd(4'd5, d); chk("R1 word0", d, VEC[k].ts[31:0]);
      rd(4'd6, d); chk("R2 word1", d, VEC[k].expW1);
      rd(4'd7, d); chk("R1 word2", d, VEC[k].expW2);
      rd(4'd8, d); chk("R1 word3", d, VEC[k].ts[63:32]);
      wr(4'd4, 32'h1);
      rd(4'd1, d); chk("R5 pop empties", d, 32'h0);
    end

    // R9 same-cycle burst: push, hw3, rx, compare
    @(negedge clk);
    curTime = 64'h55;
    pushReq = 1; hwIn[3] = 1; cmpReq = 1;
    rxReq = 1; rxPort = 5'd2; rxMsgType = 4'h1; rxSeqId = 16'h00AB; rxDomain = 8'h07;
    @(negedge clk);
    pushReq = 0; hwIn[3] = 0; cmpReq = 0; rxReq = 0;
    repeat (4) @(negedge clk);
    rd(4'd6, d); chk("R9 first push", d, 32'h0000_0000);
    wr(4'd4, 32'h1);
    rd(4'd6, d); chk("R9 second hw3", d, 32'h0430_0000);
    wr(4'd4, 32'h1);
    rd(4'd6, d); chk("R9 third rx", d, 32'h0241_00AB);
    wr(4'd4, 32'h1);
    rd(4'd6, d); chk("R9 fourth compare", d, 32'h0060_0000);
    rd(4'd5, d); chk("R9 shared stamp", d, 32'h55);
    rd(4'd1, d); chk("R7 no overflow at exact fill", d, 32'h1);
    wr(4'd4, 32'h1);
    rd(4'd1, d); chk("R4 drained", d, 32'h0);

    // R7 overflow
    for (int k = 0; k < DEPTH + 1; k++) fire(pushAt(64'(100 + k)));
    rd(4'd1, d); chk("R7 pending and overflow", d, 32'h3);
    for (int k = 0; k < DEPTH; k++) begin
      rd(4'd5, d); chk("R7 oldest kept in order", d, 32'(100 + k));
      wr(4'd4, 32'h1);
    end
    rd(4'd1, d); chk("R7 overflow sticky", d, 32'h2);
    wr(4'd1, 32'h2);
    rd(4'd1, d); chk("R7 overflow cleared", d, 32'h0);

    // R6 pop while empty
    wr(4'd4, 32'h1);
    rd(4'd1, d); chk("R6 empty pop", d, 32'h0);
    fire(pushAt(64'h0000_00C8));
    rd(4'd5, d); chk("R6 later event word0", d, 32'hC8);
    rd(4'd1, d); chk("R6 one entry", d, 32'h1);
    wr(4'd4, 32'h1);
    rd(4'd1, d); chk("R6 one entry only", d, 32'h0);

    // R3 gating and edge
    wr(4'd0, 32'h0000_FB00);
    rd(4'd0, d); chk("R3 control readback 2", d, 32'h0000_FB00);
    @(negedge clk); hwIn[2] = 1;
    repeat (3) @(negedge clk); hwIn[2] = 0;
    rd(4'd1, d); chk("R3 disabled input ignored", d, 32'h0);
    @(negedge clk); hwIn[5] = 1;
    repeat (4) @(negedge clk);
    rd(4'd6, d); chk("R3 port is index plus one", d, 32'h0630_0000);
    wr(4'd4, 32'h1);
    rd(4'd1, d); chk("R3 held level one event", d, 32'h0);
    @(negedge clk); hwIn[5] = 0;

    // R8 interrupt masking
    fire(pushAt(64'h1));
    rd(4'd2, d); chk("R8 masked off", d, 32'h0);
    chk("R8 irq off", {31'b0, irq}, 32'h0);
    wr(4'd3, 32'h1);
    rd(4'd2, d); chk("R8 masked on", d, 32'h1);
    chk("R8 irq on", {31'b0, irq}, 32'h1);
    wr(4'd4, 32'h1);
    rd(4'd2, d); chk("R8 masked after pop", d, 32'h0);
    chk("R8 irq after pop", {31'b0, irq}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule